// File: doc/BRIEF.md
# ADC Autoscan Conversion Sequencer

This block sequences an eight-input successive-approximation analog-to-digital converter. A scan is started by software, through the go bit of a single control write, or by a rising edge on an external trigger pin. The block drives the channel select of the analog multiplexer and enables the sample-and-hold for a fixed sampling window. It then runs eight binary-search trials against a comparator bit. Each trial presents a trial code on `dac_code` and keeps or drops one bit according to `cmp_in`.

Every conversion lasts a fixed number of clock cycles. Each finished code is stored in a result register owned by its channel, and any result register can be read through a small read port. With autoscan set, the scan begins at the programmed first channel and walks upward to the highest channel. With autoscan clear, only the programmed channel is converted. A done flag marks the end of the scan.

Top module: `adc_scan_seq`

## Requirements
- R1: While idle, a control write with the go bit (bit 0) set, or a 0-to-1 change of `ext_trig`, starts a scan: `busy` is high from the next cycle and `eoc` is cleared. A level held high on `ext_trig` starts only one scan.
- R2: Every conversion occupies exactly 138 cycles, and `sh_en` is high for the first 84 of them and low for the rest.
- R3: `mux_sel` carries the channel being converted and does not change within a conversion.
- R4: After sampling, eight trials of 6 cycles each run from the most significant bit down. Each trial presents the kept bits plus the trial bit on `dac_code`. `cmp_in`, sampled in the last cycle of the trial, keeps the bit when it is 1. The stored result therefore equals the input code whenever the comparator reports input >= `dac_code`.
- R5: A finished code is written only to the result register of the converted channel, and `rd_val` shows the register chosen by `rd_ch`.
- R6: With autoscan (control bit 1) set, the scan converts the start channel (control bits 4:2) and every higher channel up to 7, then stops. With autoscan clear, only the start channel is converted.
- R7: `eoc` rises in the cycle after the last conversion of a scan is written, and any control write clears it.
- R8: A trigger of either kind that arrives during a scan has no effect: the scan keeps its channel order and length.
- R9: After reset the block is idle, `eoc` and `sh_en` are low, and every result register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | Control value: bit 0 go, bit 1 autoscan, bits 4:2 start channel |
| ext_trig | input | 1 | External start; a rising edge starts a scan |
| rd_ch | input | 3 | Result register to read |
| rd_val | output | 8 | Content of the selected result register |
| cmp_in | input | 1 | Comparator answer: 1 when the input is at or above `dac_code` |
| dac_code | output | 8 | Trial code for the comparator |
| mux_sel | output | 3 | Analog channel select |
| sh_en | output | 1 | Sample-and-hold enable |
| busy | output | 1 | A scan is in progress |
| eoc | output | 1 | Scan complete flag |

## Verification
`busy` and a cleared `eoc` appear one cycle after the triggering edge. A result register changes at the edge that ends cycle 137 of its conversion. `eoc` rises at that same edge for the final channel, and `mux_sel` advances there for a channel that follows. The bench keeps a behavioural model that is stepped at every rising edge and compares `busy`, `sh_en`, `eoc`, `mux_sel` and `rd_val` with it just after each falling edge, so every output is checked in the exact cycle it is due. Scan lengths are counted as high `busy` cycles (138 per channel), and the comparator is a behavioural compare, so each stored code must equal the applied input.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_state_e;

  // Index of the trial window that cycle cnt falls in (0 = MSB trial)
  function automatic int trial_slot(input int cnt, input int sample_len, input int per_bit);
    return (cnt - sample_len) / per_bit;
  endfunction

  // True in the final cycle of a trial window, where the comparator is taken
  function automatic logic decide_cycle(input int cnt, input int sample_len, input int per_bit);
    return ((cnt - sample_len) % per_bit) == (per_bit - 1);
  endfunction

endpackage

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int CONV_CYCLES   = 138,
  parameter int SAMPLE_CYCLES = 84,
  parameter int BIT_CYCLES    = 6,
  parameter int RES_BITS      = 8,
  localparam int CNT_W = $clog2(CONV_CYCLES),
  localparam int TB_W  = $clog2(RES_BITS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  output logic            sample_ph,
  output logic            trial_ph,
  output logic            decide,
  output logic [TB_W-1:0] trial_bit,
  output logic            last
);
  import adc_seq_pkg::*;

  localparam int TRIAL_END = SAMPLE_CYCLES + RES_BITS * BIT_CYCLES;

  logic [CNT_W-1:0] cnt;
  int               ci;
  int               slot;

  always_comb begin
    ci        = int'(cnt);
    slot      = trial_slot(ci, SAMPLE_CYCLES, BIT_CYCLES);
    last      = run && (ci == CONV_CYCLES - 1);
    sample_ph = run && (ci < SAMPLE_CYCLES);
    trial_ph  = run && (ci >= SAMPLE_CYCLES) && (ci < TRIAL_END);
    decide    = trial_ph && decide_cycle(ci, SAMPLE_CYCLES, BIT_CYCLES);
    trial_bit = TB_W'(RES_BITS - 1 - slot);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || last) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/adc_sar_reg.sv
module adc_sar_reg #(
  parameter int RES_BITS = 8,
  localparam int TB_W = $clog2(RES_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                trial_en,
  input  logic [TB_W-1:0]     trial_bit,
  input  logic                decide,
  input  logic                cmp_in,
  output logic [RES_BITS-1:0] dac_code,
  output logic [RES_BITS-1:0] result
);
  logic [RES_BITS-1:0] approx;
  logic [RES_BITS-1:0] probe;

  assign probe    = {{(RES_BITS-1){1'b0}}, 1'b1} << trial_bit;
  assign dac_code = trial_en ? (approx | probe) : approx;
  assign result   = approx;

  always_ff @(posedge clk) begin
    if (!rst_n || clear)      approx <= '0;
    else if (decide && cmp_in) approx <= approx | probe;
  end

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int NCH      = 8,
  parameter int RES_BITS = 8,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [CH_W-1:0]     wr_ch,
  input  logic [RES_BITS-1:0] wr_val,
  input  logic [CH_W-1:0]     rd_ch,
  output logic [RES_BITS-1:0] rd_val
);
  logic [RES_BITS-1:0] slots [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                           slots[g] <= '0;
      else if (wr && (wr_ch == CH_W'(g)))   slots[g] <= wr_val;
    end
  end

  assign rd_val = slots[rd_ch];

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int NCH           = 8,
  parameter int RES_BITS      = 8,
  parameter int CONV_CYCLES   = 138,
  parameter int SAMPLE_CYCLES = 84,
  parameter int BIT_CYCLES    = 6,
  localparam int CH_W   = $clog2(NCH),
  localparam int CTRL_W = 2 + CH_W,
  localparam int TB_W   = $clog2(RES_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_we,
  input  logic [CTRL_W-1:0]   ctl_wdata,
  input  logic                ext_trig,
  input  logic [CH_W-1:0]     rd_ch,
  output logic [RES_BITS-1:0] rd_val,
  input  logic                cmp_in,
  output logic [RES_BITS-1:0] dac_code,
  output logic [CH_W-1:0]     mux_sel,
  output logic                sh_en,
  output logic                busy,
  output logic                eoc
);
  import adc_seq_pkg::*;

  seq_state_e          state;
  logic                cfg_auto, scan_auto, ext_q;
  logic [CH_W-1:0]     cfg_start, chan;
  logic                trig, start_evt, conv_done, scan_end;
  logic                trial_ph, decide;
  logic [TB_W-1:0]     trial_bit;
  logic [RES_BITS-1:0] result;

  // Named events used by the checker
  assign trig      = (ctl_we && ctl_wdata[0]) || (ext_trig && !ext_q);
  assign busy      = (state == SEQ_RUN);
  assign start_evt = trig && !busy;
  assign scan_end  = conv_done && (!scan_auto || (chan == CH_W'(NCH - 1)));
  assign mux_sel   = chan;

  adc_conv_timer #(
    .CONV_CYCLES(CONV_CYCLES), .SAMPLE_CYCLES(SAMPLE_CYCLES),
    .BIT_CYCLES(BIT_CYCLES), .RES_BITS(RES_BITS)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy),
    .sample_ph(sh_en), .trial_ph(trial_ph), .decide(decide),
    .trial_bit(trial_bit), .last(conv_done)
  );

  adc_sar_reg #(.RES_BITS(RES_BITS)) u_sar (
    .clk(clk), .rst_n(rst_n), .clear(sh_en), .trial_en(trial_ph),
    .trial_bit(trial_bit), .decide(decide), .cmp_in(cmp_in),
    .dac_code(dac_code), .result(result)
  );

  adc_result_bank #(.NCH(NCH), .RES_BITS(RES_BITS)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr(conv_done), .wr_ch(chan), .wr_val(result),
    .rd_ch(rd_ch), .rd_val(rd_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SEQ_IDLE;
      cfg_auto  <= 1'b0;
      cfg_start <= '0;
      scan_auto <= 1'b0;
      chan      <= '0;
      ext_q     <= 1'b0;
      eoc       <= 1'b0;
    end else begin
      ext_q <= ext_trig;
      if (ctl_we) begin
        cfg_auto  <= ctl_wdata[1];
        cfg_start <= ctl_wdata[CTRL_W-1:2];
      end
      if (scan_end)                  eoc <= 1'b1;
      else if (ctl_we || start_evt)  eoc <= 1'b0;
      case (state)
        SEQ_IDLE: if (trig) begin
          state     <= SEQ_RUN;
          chan      <= ctl_we ? ctl_wdata[CTRL_W-1:2] : cfg_start;
          scan_auto <= ctl_we ? ctl_wdata[1] : cfg_auto;
        end
        SEQ_RUN: if (conv_done) begin
          if (scan_end) state <= SEQ_IDLE;
          else          chan  <= chan + 1'b1;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int CH_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            sh_en,
  input logic            eoc,
  input logic [CH_W-1:0] mux_sel,
  input logic            conv_done,
  input logic            trig,
  input logic            start_evt
);
  // R1
  scan_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy && sh_en && !eoc);

  // R2
  sample_in_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sh_en |-> busy);

  // R3
  mux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !$past(conv_done) |-> $stable(mux_sel));

  // R7
  eoc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc) |-> $past(conv_done));

  // R7
  scan_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> eoc);

  // R8
  busy_trig_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && trig && !conv_done |=> busy && $stable(mux_sel));

endmodule

bind adc_scan_seq adc_scan_seq_chk #(.CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sh_en(sh_en), .eoc(eoc),
  .mux_sel(mux_sel), .conv_done(conv_done), .trig(trig), .start_evt(start_evt)
);

// File: tb/sim_adc_scan_seq.sv
module sim_adc_scan_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 1'b0;
  logic [4:0] ctl_wdata = '0;
  logic       ext_trig = 1'b0;
  logic [2:0] rd_ch = '0;
  logic [7:0] rd_val, dac_code;
  logic       cmp_in;
  logic [2:0] mux_sel;
  logic       sh_en, busy, eoc;

  logic [7:0] ain [8];
  int checks = 0;
  int fails = 0;
  int busy_ct = 0;
  bit finished = 1'b0;

  // model state
  int         m_busy, m_cnt, m_ch, m_eoc, m_scan_auto, m_cfg_auto, m_cfg_start;
  bit         m_ext_prev, m_trig;
  logic [7:0] m_data [8];

  always #4 clk = ~clk;

  // behavioural comparator
  assign cmp_in = (ain[mux_sel] >= dac_code);

  adc_scan_seq u0 (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ext_trig(ext_trig), .rd_ch(rd_ch), .rd_val(rd_val), .cmp_in(cmp_in),
    .dac_code(dac_code), .mux_sel(mux_sel), .sh_en(sh_en), .busy(busy), .eoc(eoc)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model, stepped on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_cnt = 0; m_ch = 0; m_eoc = 0; m_scan_auto = 0;
      m_cfg_auto = 0; m_cfg_start = 0; m_ext_prev = 0;
      for (int i = 0; i < 8; i++) m_data[i] = 8'h00;
    end else begin
      m_trig = (ctl_we && ctl_wdata[0]) || (ext_trig && !m_ext_prev);
      if (ctl_we) m_eoc = 0;
      if (m_busy == 0) begin
        if (m_trig) begin
          m_busy = 1; m_cnt = 0; m_eoc = 0;
          m_ch        = ctl_we ? int'(ctl_wdata[4:2]) : m_cfg_start;
          m_scan_auto = ctl_we ? int'(ctl_wdata[1]) : m_cfg_auto;
        end
      end else if (m_cnt == 137) begin
        m_data[m_ch] = ain[m_ch];
        if (m_scan_auto != 0 && m_ch < 7) begin
          m_ch = m_ch + 1; m_cnt = 0;
        end else begin
          m_busy = 0; m_eoc = 1;
        end
      end else begin
        m_cnt = m_cnt + 1;
      end
      if (ctl_we) begin
        m_cfg_auto  = int'(ctl_wdata[1]);
        m_cfg_start = int'(ctl_wdata[4:2]);
      end
      m_ext_prev = ext_trig;
    end
  end

  // per-cycle comparison, just after the falling edge
  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      if (busy) busy_ct++;
      check(busy == (m_busy != 0), "R1 busy", busy, m_busy);
      check(sh_en == (m_busy != 0 && m_cnt < 84), "R2 sh_en", sh_en, int'(m_busy != 0 && m_cnt < 84));
      check(eoc == (m_eoc != 0), "R7 eoc", eoc, m_eoc);
      if (m_busy != 0) check(int'(mux_sel) == m_ch, "R3 mux_sel", mux_sel, m_ch);
      check(rd_val == m_data[rd_ch], "R5 rd_val", rd_val, m_data[rd_ch]);
    end
  end

  task automatic wr_ctl(input bit go, input bit auto_en, input int ch);
    @(negedge clk);
    ctl_we = 1'b1;
    ctl_wdata = {3'(ch), auto_en, go};
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic read_ch(input int ch, output logic [7:0] v);
    @(negedge clk);
    rd_ch = 3'(ch);
    #2 v = rd_val;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int b0;
    ain[0] = 8'h00; ain[1] = 8'hFF; ain[2] = 8'h80; ain[3] = 8'h7F;
    ain[4] = 8'h01; ain[5] = 8'hA5; ain[6] = 8'h5A; ain[7] = 8'hFE;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    @(negedge clk); #2;
    check(!busy, "R9 idle after reset", busy, 0);
    check(!eoc, "R9 eoc after reset", eoc, 0);
    check(!sh_en, "R9 sh_en after reset", sh_en, 0);
    for (int i = 0; i < 8; i++) begin
      read_ch(i, v);
      check(v == 8'h00, "R9 result cleared", v, 0);
    end

    // single channel by software, channel 3
    b0 = busy_ct;
    wr_ctl(1'b1, 1'b0, 3);
    #2 check(busy, "R1 software start", busy, 1);
    wait_idle();
    check(busy_ct - b0 == 138, "R2 single conversion length", busy_ct - b0, 138);
    read_ch(3, v);
    check(v == ain[3], "R4 code on channel 3", v, ain[3]);
    read_ch(2, v);
    check(v == 8'h00, "R6 no autoscan leaves channel 2", v, 0);
    check(eoc, "R7 eoc after scan", eoc, 1);
    wr_ctl(1'b0, 1'b1, 5);
    #2 check(!eoc, "R7 write clears eoc", eoc, 0);
    check(!busy, "R1 write without go stays idle", busy, 0);

    // autoscan from 5 by software
    b0 = busy_ct;
    wr_ctl(1'b1, 1'b1, 5);
    wait_idle();
    check(busy_ct - b0 == 3 * 138, "R6 scan 5..7 length", busy_ct - b0, 3 * 138);
    for (int i = 5; i < 8; i++) begin
      read_ch(i, v);
      check(v == ain[i], "R4 autoscan code", v, ain[i]);
    end
    read_ch(4, v);
    check(v == 8'h00, "R6 channel below start untouched", v, 0);
    check(eoc, "R7 eoc after autoscan", eoc, 1);

    // external trigger with stored configuration, fresh inputs
    ain[5] = 8'h3C; ain[6] = 8'hC3; ain[7] = 8'h00;
    b0 = busy_ct;
    @(negedge clk) ext_trig = 1'b1;
    @(negedge clk) ext_trig = 1'b0;
    #2 check(busy && !eoc, "R1 ext start clears eoc", {busy, eoc}, 2);
    wait_idle();
    check(busy_ct - b0 == 3 * 138, "R6 ext scan length", busy_ct - b0, 3 * 138);
    read_ch(7, v);
    check(v == 8'h00, "R4 zero input", v, 0);

    // full scan from 0 with ext held high afterwards
    ain[0] = 8'hFF; ain[1] = 8'h00; ain[2] = 8'h7F; ain[3] = 8'h80;
    ain[4] = 8'h55; ain[5] = 8'hAA; ain[6] = 8'h01; ain[7] = 8'hFE;
    wr_ctl(1'b0, 1'b1, 0);
    b0 = busy_ct;
    @(negedge clk) ext_trig = 1'b1;
    @(negedge clk);
    wait_idle();
    check(busy_ct - b0 == 8 * 138, "R6 full scan length", busy_ct - b0, 8 * 138);
    repeat (5) @(negedge clk);
    #2 check(!busy, "R1 held level does not restart", busy, 0);
    ext_trig = 1'b0;
    for (int i = 0; i < 8; i++) begin
      read_ch(i, v);
      check(v == ain[i], "R5 full scan code", v, ain[i]);
    end

    // triggers during a scan are ignored
    b0 = busy_ct;
    wr_ctl(1'b1, 1'b0, 2);
    repeat (40) @(negedge clk);
    ext_trig = 1'b1;
    @(negedge clk) ext_trig = 1'b0;
    repeat (20) @(negedge clk);
    wr_ctl(1'b1, 1'b1, 6);
    #2 check(int'(mux_sel) == 2, "R8 channel kept", mux_sel, 2);
    wait_idle();
    check(busy_ct - b0 == 138, "R8 scan length unchanged", busy_ct - b0, 138);
    repeat (3) @(negedge clk);
    #2 check(!busy, "R8 no delayed restart", busy, 0);
    read_ch(6, v);
    check(v == ain[6], "R8 channel 6 untouched", v, ain[6]);

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule